// File: doc/BRIEF.md
# Flash Page-Write Sequencer

This block drives page programming of an on-chip flash array. Software first sets a mapping bit through an 8-bit control register, which steers byte writes on a separate load port into a one-page buffer of column latches. Each buffered byte carries a valid flag. Writing the two-byte unlock pair (50h, then A0h) to the control register starts programming. While programming runs, a busy output is high, and software polls it to learn when the page is done.

The page and the bank that get programmed both come from the most recent accepted load. No separate address register holds them. The flash array is a behavioural model. It holds the page for a fixed, parameter-set number of cycles and then writes every valid buffered byte in one step. At that same step it clears the buffer. A read port lets the contents of the array be observed. Interrupt masking is left to software.

The model array keeps only the lowest MODEL_PG_W bits of the page number. Higher page numbers therefore alias onto those model pages. This keeps the storage small while the bank and page selection logic stays complete.

Top module: `flash_page_writer`

## Requirements
- R1: After reset, busy and the mapping bit are 0, and every array location reads FFh.
- R2: A control write of A0h starts programming only if the control write just before it was 50h. Busy rises in the cycle after the A0h write.
- R3: Once busy has risen, it stays high for exactly PROG_CYCLES clock cycles and then returns to 0.
- R4: Any control write other than A0h that follows 50h cancels the unlock. An A0h write that does not directly follow 50h does not start programming.
- R5: Writing ABh to the control register sets the mapping bit. Writing 53h or 00h clears it. A load is accepted only while the mapping bit is 1.
- R6: In a load address, the low log2(PAGE_BYTES) bits select the byte in the buffer and the upper bits form the page number. The target page and the 3-bit bank come from the last accepted load. The model array location is {bank, low MODEL_PG_W page bits, byte offset}.
- R7: Only buffer bytes loaded since the last clear are programmed. All other bytes of the target page keep their previous contents.
- R8: A load made while busy is 1 is dropped. It changes neither the buffer nor the target.
- R9: The buffer and its valid flags are cleared when programming completes. A later page therefore receives no bytes from an earlier one.
- R10: An unlock pair written while busy is 1 does not start another program operation.
- R11: A load in the same cycle as the launching A0h write is accepted and is included in the page being programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ld_we | input | 1 | Column-latch load strobe |
| ld_addr | input | ADDR_W | Load address (byte offset and page number) |
| ld_data | input | 8 | Load data byte |
| ld_bank | input | BANK_W | Bank select sampled with each load |
| rd_addr | input | ARR_AW | Array read address |
| rd_data | output | 8 | Array read data (combinational) |
| busy | output | 1 | Programming in progress |
| map_en | output | 1 | Mapping bit: loads go to the buffer |

## Verification
The launching A0h control write and a column-latch load can land in the same clock cycle. The bench provokes this by driving both strobes on one edge. It then reads the target location back after busy falls and expects the byte loaded in that cycle to be present. A second collision happens at the completion edge, where the buffer clear coincides with the end of busy. A load made in the final busy cycle must be dropped rather than survive the clear. A reference model inside the bench applies the same cycle ordering and compares busy, the mapping bit and the read data on every clock.

// File: rtl/fpw_pkg.sv
// Package: control-register command codes shared by the sequencer modules.
// Assumes an 8-bit control register.
package fpw_pkg;
    localparam logic [7:0] CMD_UNLOCK1 = 8'h50;
    localparam logic [7:0] CMD_UNLOCK2 = 8'hA0;
    localparam logic [7:0] CMD_MAP_ON  = 8'hAB;
    localparam logic [7:0] CMD_MAP_OFF = 8'h53;
    localparam logic [7:0] CMD_RESTORE = 8'h00;
endpackage

// File: rtl/fpw_cmd_decode.sv
// Decodes control-register writes. It tracks the unlock pair, keeps the
// mapping bit, and issues a one-cycle launch pulse.
// Assumes busy_i comes from the array model's registered busy flag.
module fpw_cmd_decode
    import fpw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we_i,
    input  logic [7:0] wdata_i,
    input  logic       busy_i,
    output logic       map_en_o,
    output logic       launch_o
);
    logic armed_q;
    logic map_q;

    // Remember whether the previous control write was the first unlock byte; update the mapping bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            map_q   <= 1'b0;
        end else if (we_i) begin
            armed_q <= (wdata_i == CMD_UNLOCK1);
            if (wdata_i == CMD_MAP_ON)
                map_q <= 1'b1;
            else if (wdata_i == CMD_MAP_OFF || wdata_i == CMD_RESTORE)
                map_q <= 1'b0;
        end
    end

    // Launch on the second unlock byte when idle.
    always_comb launch_o = we_i && (wdata_i == CMD_UNLOCK2) && armed_q && !busy_i;

    assign map_en_o = map_q;
endmodule

// File: rtl/fpw_col_latch.sv
// Page buffer of column latches with per-byte valid flags. It captures the
// target page and bank on every accepted load.
// Assumes commit_i pulses only while busy_i is high.
module fpw_col_latch #(
    parameter int PAGE_BYTES = 128,
    parameter int ADDR_W     = 16,
    parameter int BANK_W     = 3,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int PG_W      = ADDR_W - OFF_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           ld_we_i,
    input  logic [ADDR_W-1:0]              ld_addr_i,
    input  logic [7:0]                     ld_data_i,
    input  logic [BANK_W-1:0]              ld_bank_i,
    input  logic                           map_en_i,
    input  logic                           busy_i,
    input  logic                           commit_i,
    output logic [PAGE_BYTES-1:0][7:0]     buf_o,
    output logic [PAGE_BYTES-1:0]          valid_o,
    output logic [PG_W-1:0]                page_o,
    output logic [BANK_W-1:0]              bank_o
);
    logic [PAGE_BYTES-1:0][7:0] buf_q;
    logic [PAGE_BYTES-1:0]      valid_q;
    logic [PG_W-1:0]            page_q;
    logic [BANK_W-1:0]          bank_q;
    logic                       accept;

    // A load counts only when mapped and idle.
    always_comb accept = ld_we_i && map_en_i && !busy_i;

    // Store the byte and capture the target, or clear everything on commit.
    always_ff @(posedge clk) begin
        if (!rst_n || commit_i) begin
            buf_q   <= '0;
            valid_q <= '0;
            if (!rst_n) begin
                page_q <= '0;
                bank_q <= '0;
            end
        end else if (accept) begin
            buf_q[ld_addr_i[OFF_W-1:0]]   <= ld_data_i;
            valid_q[ld_addr_i[OFF_W-1:0]] <= 1'b1;
            page_q <= ld_addr_i[ADDR_W-1:OFF_W];
            bank_q <= ld_bank_i;
        end
    end

    assign buf_o   = buf_q;
    assign valid_o = valid_q;
    assign page_o  = page_q;
    assign bank_o  = bank_q;

    // R8
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i && !commit_i |=> $stable(valid_q) && $stable(buf_q) && $stable(page_q));
    // R9
    clear_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> (valid_q == '0));
    // R5
    unmapped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !map_en_i && !commit_i |=> $stable(valid_q));
endmodule

// File: rtl/fpw_array_model.sv
// Behavioural flash array. It stays busy for PROG_CYCLES cycles after a
// launch and then writes the valid buffered bytes into the target page.
// Assumes launch_i is blocked by the caller while busy.
module fpw_array_model #(
    parameter int PAGE_BYTES  = 128,
    parameter int ADDR_W      = 16,
    parameter int BANK_W      = 3,
    parameter int MODEL_PG_W  = 1,
    parameter int PROG_CYCLES = 20,
    localparam int OFF_W      = $clog2(PAGE_BYTES),
    localparam int PG_W       = ADDR_W - OFF_W,
    localparam int ARR_AW     = BANK_W + MODEL_PG_W + OFF_W,
    localparam int DEPTH      = 1 << ARR_AW,
    localparam int CNT_W      = $clog2(PROG_CYCLES + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       launch_i,
    input  logic [PAGE_BYTES-1:0][7:0] buf_i,
    input  logic [PAGE_BYTES-1:0]      valid_i,
    input  logic [PG_W-1:0]            page_i,
    input  logic [BANK_W-1:0]          bank_i,
    input  logic [ARR_AW-1:0]          rd_addr_i,
    output logic [7:0]                 rd_data_o,
    output logic                       busy_o,
    output logic                       commit_o
);
    logic [7:0]       mem_q [DEPTH];
    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    // Final busy cycle: the page is written at the closing edge.
    always_comb commit_o = busy_q && (cnt_q == CNT_W'(1));

    // Busy window timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (launch_i) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(PROG_CYCLES);
        end else if (busy_q) begin
            cnt_q  <= cnt_q - CNT_W'(1);
            if (commit_o)
                busy_q <= 1'b0;
        end
    end

    // Array storage: erased at reset, valid bytes written on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < DEPTH; j++)
                mem_q[j] <= 8'hFF;
        end else if (commit_o) begin
            for (int i = 0; i < PAGE_BYTES; i++)
                if (valid_i[i])
                    mem_q[{bank_i, page_i[MODEL_PG_W-1:0], OFF_W'(i)}] <= buf_i[i];
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];
    assign busy_o    = busy_q;

    // R2
    busy_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(launch_i));
    // R3
    busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q != '0) && (cnt_q <= CNT_W'(PROG_CYCLES)));
    // R10
    no_relaunch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !commit_o |=> busy_q && (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/flash_page_writer.sv
// Top level of the flash page-write sequencer. It connects the command
// decoder, the column-latch buffer and the behavioural array model.
// Assumes a single clock and synchronous active-low reset.
module flash_page_writer #(
    parameter int PAGE_BYTES  = 128,
    parameter int ADDR_W      = 16,
    parameter int BANK_W      = 3,
    parameter int MODEL_PG_W  = 1,
    parameter int PROG_CYCLES = 20,
    localparam int OFF_W      = $clog2(PAGE_BYTES),
    localparam int PG_W       = ADDR_W - OFF_W,
    localparam int ARR_AW     = BANK_W + MODEL_PG_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [7:0]        ctl_wdata,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [7:0]        ld_data,
    input  logic [BANK_W-1:0] ld_bank,
    input  logic [ARR_AW-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              map_en
);
    logic                       launch;
    logic                       commit;
    logic [PAGE_BYTES-1:0][7:0] buf_w;
    logic [PAGE_BYTES-1:0]      valid_w;
    logic [PG_W-1:0]            page_w;
    logic [BANK_W-1:0]          bank_w;

    fpw_cmd_decode u_cmd (
        .clk(clk), .rst_n(rst_n), .we_i(ctl_we), .wdata_i(ctl_wdata),
        .busy_i(busy), .map_en_o(map_en), .launch_o(launch)
    );

    fpw_col_latch #(
        .PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W), .BANK_W(BANK_W)
    ) u_latch (
        .clk(clk), .rst_n(rst_n), .ld_we_i(ld_we), .ld_addr_i(ld_addr),
        .ld_data_i(ld_data), .ld_bank_i(ld_bank), .map_en_i(map_en),
        .busy_i(busy), .commit_i(commit), .buf_o(buf_w), .valid_o(valid_w),
        .page_o(page_w), .bank_o(bank_w)
    );

    fpw_array_model #(
        .PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W), .BANK_W(BANK_W),
        .MODEL_PG_W(MODEL_PG_W), .PROG_CYCLES(PROG_CYCLES)
    ) u_array (
        .clk(clk), .rst_n(rst_n), .launch_i(launch), .buf_i(buf_w),
        .valid_i(valid_w), .page_i(page_w), .bank_i(bank_w),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .busy_o(busy),
        .commit_o(commit)
    );
endmodule

// File: tb/flash_page_writer_bench.sv
`timescale 1ns/1ps
module flash_page_writer_bench;
    localparam int PAGE  = 128;
    localparam int PROG  = 20;
    localparam int AW    = 11;
    localparam int DEPTH = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [7:0]  ctl_wdata = '0;
    logic        ld_we = 1'b0;
    logic [15:0] ld_addr = '0;
    logic [7:0]  ld_data = '0;
    logic [2:0]  ld_bank = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]  rd_data;
    logic        busy;
    logic        map_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    flash_page_writer u_flash_page_writer (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data), .ld_bank(ld_bank),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .map_en(map_en)
    );

    // Behavioural reference model
    int m_mem [DEPTH];
    int m_buf [PAGE];
    bit m_val [PAGE];
    int m_page, m_bank, m_cnt;
    bit m_busy, m_map, m_armed;

    always @(posedge clk) begin
        bit pb, pm, pa;
        if (!rst_n) begin
            for (int j = 0; j < DEPTH; j++) m_mem[j] = 255;
            for (int i = 0; i < PAGE; i++) begin m_buf[i] = 0; m_val[i] = 0; end
            m_page = 0; m_bank = 0; m_cnt = 0;
            m_busy = 0; m_map = 0; m_armed = 0;
        end else begin
            pb = m_busy; pm = m_map; pa = m_armed;
            if (pb) begin
                if (m_cnt == 1) begin
                    for (int i = 0; i < PAGE; i++) begin
                        if (m_val[i]) m_mem[m_bank * 256 + (m_page % 2) * 128 + i] = m_buf[i];
                        m_val[i] = 0; m_buf[i] = 0;
                    end
                    m_busy = 0;
                end
                m_cnt = m_cnt - 1;
            end
            if (ld_we && pm && !pb) begin
                m_buf[ld_addr % PAGE] = ld_data;
                m_val[ld_addr % PAGE] = 1;
                m_page = ld_addr / PAGE;
                m_bank = ld_bank;
            end
            if (ctl_we) begin
                if (ctl_wdata == 8'hA0 && pa && !pb) begin m_busy = 1; m_cnt = PROG; end
                m_armed = (ctl_wdata == 8'h50);
                if (ctl_wdata == 8'hAB) m_map = 1;
                else if (ctl_wdata == 8'h53 || ctl_wdata == 8'h00) m_map = 0;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare with the model on every clock, away from the edges.
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            check("R3 busy vs model", busy, m_busy);
            check("R5 map_en vs model", map_en, m_map);
            check("R7 rd_data vs model", rd_data, m_mem[rd_addr]);
        end
    end

    task automatic ctl(input logic [7:0] d);
        @(negedge clk); ctl_we = 1; ctl_wdata = d;
        @(negedge clk); ctl_we = 0;
    endtask

    task automatic ld(input int page, input int off, input int bank, input int d);
        @(negedge clk); ld_we = 1; ld_addr = 16'(page * PAGE + off);
        ld_bank = 3'(bank); ld_data = 8'(d);
        @(negedge clk); ld_we = 0;
    endtask

    task automatic peek(input int a, input int exp, input string req);
        @(negedge clk); rd_addr = AW'(a);
        #3; check(req, rd_data, exp);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic launch_measure(input string req);
        int n;
        ctl(8'h50); ctl(8'hA0);
        check("R2 busy after unlock pair", busy, 1);
        n = 0;
        while (busy) begin @(negedge clk); n++; end
        check(req, n, PROG);
    endtask

    initial begin
        #(8 * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy at reset", busy, 0);
        check("R1 map_en at reset", map_en, 0);
        peek(0, 8'hFF, "R1 erased");
        peek(DEPTH - 1, 8'hFF, "R1 erased");

        // Basic page program
        ctl(8'hAB);
        check("R5 ABh sets map_en", map_en, 1);
        ld(3, 5, 2, 8'h5A);
        ld(3, 10, 2, 8'hC3);
        launch_measure("R3 busy length");
        @(negedge clk);
        peek(645, 8'h5A, "R6 byte offset 5");
        peek(650, 8'hC3, "R6 byte offset 10");
        peek(646, 8'hFF, "R7 unloaded byte untouched");

        // R6 target from the last load
        ld(0, 1, 0, 8'h11);
        ld(1, 2, 5, 8'h22);
        launch_measure("R3 busy length");
        @(negedge clk);
        peek(5 * 256 + 128 + 1, 8'h11, "R6 last page and bank");
        peek(5 * 256 + 128 + 2, 8'h22, "R6 last page and bank");
        peek(1, 8'hFF, "R6 first load page not used");

        // R4 aborted unlock
        ld(2, 7, 1, 8'h77);
        ctl(8'h50); ctl(8'h12); ctl(8'hA0);
        check("R4 aborted unlock", busy, 0);
        ctl(8'hA0);
        check("R4 lone A0h", busy, 0);
        launch_measure("R3 busy length");
        @(negedge clk);
        peek(263, 8'h77, "R4 later full unlock");

        // R5 loads ignored while unmapped
        ctl(8'h53);
        check("R5 53h clears map_en", map_en, 0);
        ld(2, 8, 1, 8'h88);
        ctl(8'hAB); ctl(8'h00);
        check("R5 00h clears map_en", map_en, 0);
        ld(2, 9, 1, 8'h99);
        ctl(8'hAB);
        ld(2, 20, 1, 8'h20);
        launch_measure("R3 busy length");
        @(negedge clk);
        peek(264, 8'hFF, "R5 unmapped load dropped");
        peek(265, 8'hFF, "R5 unmapped load dropped");
        peek(276, 8'h20, "R5 mapped load kept");

        // R8 loads dropped while busy
        ld(0, 30, 3, 8'h30);
        ctl(8'h50); ctl(8'hA0);
        ld(0, 31, 3, 8'h31);
        // R10 unlock pair while busy
        ctl(8'h50); ctl(8'hA0);
        while (busy) @(negedge clk);
        check("R10 no relaunch", busy, 0);
        @(negedge clk);
        check("R10 still idle", busy, 0);
        peek(798, 8'h30, "R8 pre-busy load kept");
        peek(799, 8'hFF, "R8 busy load dropped");

        // R9 buffer cleared after completion
        ld(0, 40, 4, 8'h44);
        launch_measure("R3 busy length");
        @(negedge clk);
        peek(4 * 256 + 40, 8'h44, "R9 new byte");
        peek(4 * 256 + 30, 8'hFF, "R9 no stale byte");

        // R11 load in the launch cycle
        ctl(8'h50);
        @(negedge clk);
        ctl_we = 1; ctl_wdata = 8'hA0;
        ld_we = 1; ld_addr = 16'(PAGE + 50); ld_bank = 3'd6; ld_data = 8'h66;
        @(negedge clk);
        ctl_we = 0; ld_we = 0;
        check("R11 launch with load", busy, 1);
        wait_idle();
        peek(6 * 256 + 128 + 50, 8'h66, "R11 same-cycle load programmed");

        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule